// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is a byte-at-a-time I2C bus master driven by a CPU through four 8-bit registers. Software loads a slave address or a data byte into the data register and writes a mode word to the status register. The engine then puts a START on the bus and shifts the byte out. It samples or drives the acknowledge bit, and finally stops with SCL held low. A pending flag in the control register marks that stop, and an interrupt line is raised when that is enabled. The bus stays frozen until software clears the pending flag, sends a repeated START or asks for a STOP.

The SCL rate is set by a prescaler with two choices (divide by 16 or by 512) followed by a 4-bit divider. Each bit is split into four equal quarters. SCL is low in the first two quarters and released in the last two. SDA is moved only in the second quarter, and the bus is sampled at the end of the fourth. The bus pins are open-drain: the block outputs pull-low enables and reads the resolved SDA level back.

Register addresses: 0 is control, 1 is status, 2 is own address and 3 is data.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset all four registers read 0, both pull-low enables are 0 and irq is 0.
- R2: The control register (address 0) holds these fields: bit 7 enables ACK generation, bit 6 selects prescaler 512 (1) or 16 (0), bit 5 enables the interrupt, bit 4 is the pending flag and bits 3:0 are the divider. All fields read back as written, except bit 4: writing 1 to it neither sets pending nor releases a held byte.
- R3: The SCL period is P*(D+1) clock cycles, where P is 16 or 512 from control bit 6 and D is control bits 3:0.
- R4: A write to status (address 1) with bit 7=1, bit 5=1 and bit 4=1 while the bus is idle issues a START (SDA falls while SCL is high) and sends the data register MSB first as the address byte. Status bit 5 reads 1 from the next cycle until the STOP completes.
- R5: In master transmit (status bits 7:6 = 2'b11) each byte is driven MSB first. SDA changes only while SCL is low, and the two lines never change in the same cycle. The acknowledge slot is sampled into status bit 0 (1 = NACK, 0 = ACK).
- R6: After every acknowledge slot, pending (control bit 4) is set and irq equals pending AND control bit 5. While pending is set, SCL is held low and SDA does not change.
- R7: Writing control with bit 4 = 0 while pending clears pending and starts the next byte.
- R8: In master receive (status bits 7:6 = 2'b10), every byte after the address is sampled MSB first into the data register. The master pulls SDA low in the acknowledge slot when control bit 7 is 1 and leaves it released (NACK) when it is 0.
- R9: A status write with bit 5 = 1 while pending gives a repeated START: SDA rises while SCL is low, SCL rises, then SDA falls while SCL is high. No STOP appears in between.
- R10: A status write with bit 5 = 0 while pending gives a STOP: SDA rises while SCL is high. After that, status bit 5 reads 0 and both lines are released.
- R11: Writes to the data register are ignored while a byte is moving on the bus. While pending is set, the data register holds the byte that was just on the bus (sent or received).
- R12: The own-address register (address 2) stores and returns an 8-bit value and has no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select (0 control, 1 status, 2 own address, 3 data) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| sdaIn | input | 1 | Resolved SDA level from the pad |
| sclDriveLow | output | 1 | Pull SCL low when 1 |
| sdaDriveLow | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Pending flag qualified by interrupt enable |

## Verification
On every cycle the assertions check several line rules: SCL and SDA never move together, a held byte keeps SCL low with SDA frozen, and both lines stay released while idle. They also check that the data register cannot change while a byte is shifting, that pending implies busy, and that quarter ticks never come back to back. Only the bench scenarios, run against a behavioural slave, can show the rest: the exact SCL period for each prescaler and divider setting, the correct byte values and acknowledge polarity in both directions, and that a repeated START arrives with no STOP before it.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_OWN  = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_HOLD,
    ST_STOP
  } engState_t;

  // datapath -> control: decoded software requests and current settings
  typedef struct packed {
    logic startReq;
    logic stopReq;
    logic resumeReq;
    logic masterTx;
    logic ackEn;
    logic txBit;
  } dpReq_t;

  // control -> datapath: strobes and engine state
  typedef struct packed {
    logic shiftStb;
    logic ackStb;
    logic byteDone;
    logic lineBit;
    logic busy;
    logic holding;
  } ctlStb_t;

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int PRE_LO   = 16,
  parameter int PRE_HI   = 512,
  parameter int DIV_W    = 4,
  parameter int QUARTERS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             preSel,
  input  logic [DIV_W-1:0] divVal,
  output logic             tick
);
  localparam int MAX_CNT = (PRE_HI / QUARTERS) * (1 << DIV_W);
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;
  logic             atEnd;

  always_comb begin
    limit = (preSel ? CNT_W'(PRE_HI / QUARTERS) : CNT_W'(PRE_LO / QUARTERS))
          * (CNT_W'(divVal) + CNT_W'(1));
    atEnd = (cnt == limit - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (atEnd)     cnt <= '0;
    else                cnt <= cnt + CNT_W'(1);
  end

  assign tick = run && atEnd;

  // a quarter lasts at least two cycles, so ticks are never adjacent
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick); // R3

endmodule

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  ctlStb_t           stb,
  output dpReq_t            req,
  output logic              preSel,
  output logic [DIV_W-1:0]  divVal,
  output logic              irq
);
  logic              ackEnQ, preSelQ, intEnQ, pendingQ;
  logic [DIV_W-1:0]  divQ;
  logic [1:0]        modeQ;
  logic              txrxEnQ, nackQ;
  logic [DATA_W-1:0] ownQ, dataQ;

  logic wrCtrl, wrStat, wrOwn, wrData_;
  logic canStart;

  always_comb begin
    wrCtrl   = wrEn && (addr == REG_CTRL);
    wrStat   = wrEn && (addr == REG_STAT);
    wrOwn    = wrEn && (addr == REG_OWN);
    wrData_  = wrEn && (addr == REG_DATA);
    canStart = !stb.busy || stb.holding;

    req.startReq  = wrStat && wrData[7] && wrData[5] && wrData[4] && canStart;
    req.stopReq   = wrStat && !wrData[5] && stb.holding;
    req.resumeReq = wrCtrl && !wrData[4] && pendingQ && stb.holding;
    req.masterTx  = (modeQ == 2'b11);
    req.ackEn     = ackEnQ;
    req.txBit     = dataQ[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackEnQ   <= 1'b0;
      preSelQ  <= 1'b0;
      intEnQ   <= 1'b0;
      divQ     <= '0;
      pendingQ <= 1'b0;
      modeQ    <= 2'b00;
      txrxEnQ  <= 1'b0;
      nackQ    <= 1'b0;
      ownQ     <= '0;
      dataQ    <= '0;
    end else begin
      if (wrCtrl) begin
        ackEnQ  <= wrData[7];
        preSelQ <= wrData[6];
        intEnQ  <= wrData[5];
        divQ    <= wrData[DIV_W-1:0];
      end
      if (stb.byteDone)
        pendingQ <= 1'b1;
      else if (req.resumeReq || req.startReq || req.stopReq)
        pendingQ <= 1'b0;
      if (wrStat && canStart) begin
        modeQ   <= wrData[7:6];
        txrxEnQ <= wrData[4];
      end
      if (stb.ackStb)
        nackQ <= stb.lineBit;
      if (wrOwn)
        ownQ <= wrData;
      if (stb.shiftStb)
        dataQ <= {dataQ[DATA_W-2:0], stb.lineBit};
      else if (wrData_ && canStart)
        dataQ <= wrData;
    end
  end

  always_comb begin
    unique case (addr)
      REG_CTRL: rdData = {ackEnQ, preSelQ, intEnQ, pendingQ, divQ};
      REG_STAT: rdData = {modeQ, stb.busy, txrxEnQ, 3'b000, nackQ};
      REG_OWN:  rdData = ownQ;
      default:  rdData = dataQ;
    endcase
  end

  assign preSel = preSelQ;
  assign divVal = divQ;
  assign irq    = pendingQ && intEnQ;

  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.busy && !stb.holding && !stb.shiftStb) |=> $stable(dataQ)); // R11

  AST_PENDING_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    pendingQ |-> stb.busy); // R6

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int BITS_PER_BYTE = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  dpReq_t  req,
  input  logic    sdaIn,
  output ctlStb_t stb,
  output logic    run,
  output logic    sclLow,
  output logic    sdaLow
);
  localparam int BC_W = $clog2(BITS_PER_BYTE + 1);
  localparam logic [BC_W-1:0] ACK_SLOT = BC_W'(BITS_PER_BYTE);

  engState_t       state;
  logic [1:0]      quarter;
  logic [BC_W-1:0] bitCnt;
  logic            firstByte;
  logic            txByte, lastQ, inAck;
  logic            sclNext, sdaNext;

  always_comb begin
    txByte = req.masterTx || firstByte;
    lastQ  = tick && (quarter == 2'd3);
    inAck  = (bitCnt == ACK_SLOT);
    run    = (state == ST_START) || (state == ST_BITS) || (state == ST_STOP);

    stb.shiftStb = (state == ST_BITS) && lastQ && !inAck;
    stb.ackStb   = (state == ST_BITS) && lastQ && inAck && txByte;
    stb.byteDone = (state == ST_BITS) && lastQ && inAck;
    stb.lineBit  = sdaIn;
    stb.busy     = (state != ST_IDLE);
    stb.holding  = (state == ST_HOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      quarter   <= 2'd0;
      bitCnt    <= '0;
      firstByte <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req.startReq) begin
          state     <= ST_START;
          quarter   <= 2'd0;
          firstByte <= 1'b1;
        end
        ST_HOLD: begin
          if (req.startReq) begin
            state     <= ST_START;
            quarter   <= 2'd0;
            firstByte <= 1'b1;
          end else if (req.stopReq) begin
            state   <= ST_STOP;
            quarter <= 2'd0;
          end else if (req.resumeReq) begin
            state   <= ST_BITS;
            quarter <= 2'd0;
            bitCnt  <= '0;
          end
        end
        ST_START: if (tick) begin
          quarter <= quarter + 2'd1;
          if (quarter == 2'd3) begin
            state  <= ST_BITS;
            bitCnt <= '0;
          end
        end
        ST_BITS: if (tick) begin
          quarter <= quarter + 2'd1;
          if (quarter == 2'd3) begin
            if (inAck) begin
              state     <= ST_HOLD;
              firstByte <= 1'b0;
            end else begin
              bitCnt <= bitCnt + BC_W'(1);
            end
          end
        end
        ST_STOP: if (tick) begin
          quarter <= quarter + 2'd1;
          if (quarter == 2'd3) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // line levels per state and quarter; unlisted lines keep their value
  always_comb begin
    sclNext = sclLow;
    sdaNext = sdaLow;
    unique case (state)
      ST_IDLE: begin
        sclNext = 1'b0;
        sdaNext = 1'b0;
      end
      ST_START: begin
        if (quarter == 2'd0)      sdaNext = 1'b0;
        else if (quarter == 2'd1) sclNext = 1'b0;
        else begin
          sclNext = 1'b0;
          sdaNext = 1'b1;
        end
      end
      ST_BITS: begin
        if (quarter == 2'd0) sclNext = 1'b1;
        else if (quarter == 2'd1) begin
          sclNext = 1'b1;
          if (inAck) sdaNext = txByte ? 1'b0 : req.ackEn;
          else       sdaNext = txByte ? !req.txBit : 1'b0;
        end else sclNext = 1'b0;
      end
      ST_HOLD: sclNext = 1'b1;
      ST_STOP: begin
        if (quarter == 2'd0) begin
          sclNext = 1'b1;
          sdaNext = 1'b1;
        end else if (quarter == 2'd1) sclNext = 1'b0;
        else begin
          sclNext = 1'b0;
          sdaNext = 1'b0;
        end
      end
      default: begin
        sclNext = 1'b0;
        sdaNext = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclLow <= 1'b0;
      sdaLow <= 1'b0;
    end else begin
      sclLow <= sclNext;
      sdaLow <= sdaNext;
    end
  end

  AST_NO_JOINT_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !(!$stable(sclLow) && !$stable(sdaLow))); // R5

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && $past(state == ST_HOLD)) |-> (sclLow && $stable(sdaLow))); // R6

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state == ST_IDLE)) |-> (!sclLow && !sdaLow)); // R10

  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BITS) |-> (bitCnt <= ACK_SLOT)); // R5

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2cm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 4,
  parameter int PRE_LO   = 16,
  parameter int PRE_HI   = 512,
  parameter int QUARTERS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic              irq
);
  dpReq_t           req;
  ctlStb_t          stb;
  logic             run, tick, preSel;
  logic [DIV_W-1:0] divVal;

  i2cm_datapath #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr),
    .wrData(regWrData), .rdData(regRdData), .stb(stb), .req(req),
    .preSel(preSel), .divVal(divVal), .irq(irq)
  );

  i2cm_tick #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(DIV_W),
              .QUARTERS(QUARTERS)) u_tick (
    .clk(clk), .rstN(rstN), .run(run), .preSel(preSel),
    .divVal(divVal), .tick(tick)
  );

  i2cm_ctrl #(.BITS_PER_BYTE(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .req(req), .sdaIn(sdaIn),
    .stb(stb), .run(run), .sclLow(sclDriveLow), .sdaLow(sdaDriveLow)
  );

endmodule

// File: tb/sim_i2c_byte_engine.sv
module sim_i2c_byte_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam logic [6:0] SLV_ADDR = 7'h50;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       sclDriveLow, sdaDriveLow, irq;
  logic       slvLow = 1'b0;
  logic       sclLine, sdaLine;

  assign sclLine = !sclDriveLow;
  assign sdaLine = !(sdaDriveLow || slvLow);

  i2c_byte_engine u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // row: [31] prescaler select, [30:27] divider, [26] irq enable,
  //      [25] expected NACK, [23:16] address byte, [15:0] SCL period
  localparam logic [31:0] VEC [4] = '{
    {1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 8'hA0, 16'd16},
    {1'b0, 4'd3,  1'b0, 1'b1, 1'b0, 8'hB2, 16'd64},
    {1'b0, 4'd15, 1'b1, 1'b0, 1'b0, 8'hA0, 16'd256},
    {1'b1, 4'd1,  1'b0, 1'b0, 1'b0, 8'hA0, 16'd1024}
  };

  function automatic logic [7:0] pat(int i);
    return 8'h96 + 8'(i * 37);
  endfunction

  // ---------------- behavioural slave ----------------
  int   startCnt = 0, stopCnt = 0, rxCount = 0, txIdx = 0, bitCnt = 0, byteIdx = 0;
  logic slvActive = 0, readMode = 0, txGo = 0, slvTxing = 0;
  logic prevScl = 1, prevSda = 1;
  logic [7:0] sh = 0, txSh = 0;
  logic [7:0] rxMem [8];
  logic       masterAck [8];

  initial forever @(negedge clk) begin
    if (prevScl && sclLine && prevSda && !sdaLine) begin
      startCnt++; slvActive = 1; bitCnt = 0; byteIdx = 0; txIdx = 0;
      readMode = 0; txGo = 0; slvTxing = 0; slvLow = 0;
    end else if (prevScl && sclLine && !prevSda && sdaLine) begin
      stopCnt++; slvActive = 0; slvTxing = 0; slvLow = 0;
    end else if (slvActive && sclLine && !prevScl) begin
      if (bitCnt < 8) sh = {sh[6:0], sdaLine};
      else if (slvTxing) begin
        masterAck[(txIdx - 1) % 8] = sdaLine;
        txGo = !sdaLine;
      end
      bitCnt++;
    end else if (slvActive && !sclLine && prevScl) begin
      if (bitCnt == 8) begin
        if (slvTxing) slvLow = 0;
        else if (byteIdx == 0) begin
          if (sh[7:1] == SLV_ADDR) begin
            slvLow = 1; readMode = sh[0]; txGo = sh[0]; byteIdx++;
          end else begin
            slvLow = 0; slvActive = 0;
          end
        end else begin
          rxMem[rxCount % 8] = sh; rxCount++;
          slvLow = (sh != 8'hFF); byteIdx++;
        end
      end else if (bitCnt == 9) begin
        bitCnt = 0; slvLow = 0; slvTxing = 0;
        if (readMode && txGo) begin
          txSh = pat(txIdx); txIdx++; slvTxing = 1; slvLow = !txSh[7];
        end
      end else if (bitCnt >= 1 && bitCnt <= 7 && slvTxing) begin
        slvLow = !txSh[7 - bitCnt];
      end
    end
    prevScl = sclLine;
    prevSda = sdaLine;
  end

  // ---------------- helpers ----------------
  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitPend();
    logic [7:0] v;
    do regRead(2'd0, v); while (!v[4]);
  endtask

  task automatic waitIdle();
    logic [7:0] v;
    do regRead(2'd1, v); while (v[5]);
  endtask

  task automatic waitSclRise(output int cyc);
    logic p;
    p = sclLine;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (sclLine && !p) break;
      p = sclLine;
    end
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
        finishRun();
      end
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] v;
    int d, per, s0, p0;
    logic holdOk;
    logic sdaRef;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), v);
      checkEq("R1 register reset", {24'd0, v}, 32'h0);
    end
    checkEq("R1 lines released", {30'd0, sclDriveLow, sdaDriveLow}, 32'h0);
    checkEq("R1 irq low", {31'd0, irq}, 32'h0);

    // R2 control fields, pending cannot be set by software
    regWrite(2'd0, 8'hFF);
    regRead(2'd0, v);
    checkEq("R2 control readback", {24'd0, v}, 32'hEF);
    checkEq("R2 irq stays low", {31'd0, irq}, 32'h0);

    // R12 own address register
    regWrite(2'd2, 8'h5A);
    regRead(2'd2, v);
    checkEq("R12 own address readback", {24'd0, v}, 32'h5A);
    repeat (20) @(negedge clk);
    checkEq("R12 bus untouched", {30'd0, sclDriveLow, sdaDriveLow}, 32'h0);

    // vector table: SCL period, START, address ACK/NACK, STOP
    foreach (VEC[i]) begin
      s0 = startCnt; p0 = stopCnt;
      regWrite(2'd0, {1'b1, VEC[i][31], VEC[i][26], 1'b0, VEC[i][30:27]});
      regWrite(2'd3, VEC[i][23:16]);
      regWrite(2'd1, 8'hF0);
      regRead(2'd1, v);
      checkEq("R4 busy after start", {31'd0, v[5]}, 32'd1);
      waitSclRise(d);
      waitSclRise(per);
      checkEq("R3 SCL period", per, {16'd0, VEC[i][15:0]});
      waitPend();
      checkEq("R4 START seen", startCnt - s0, 1);
      regRead(2'd1, v);
      checkEq("R5 ack status bit0", {31'd0, v[0]}, {31'd0, VEC[i][25]});
      checkEq("R6 irq follows enable", {31'd0, irq}, {31'd0, VEC[i][26]});
      regRead(2'd3, v);
      checkEq("R11 data holds sent address", {24'd0, v}, {24'd0, VEC[i][23:16]});
      regWrite(2'd1, 8'hD0);
      waitIdle();
      checkEq("R10 STOP seen", stopCnt - p0, 1);
      checkEq("R10 lines released", {30'd0, sclDriveLow, sdaDriveLow}, 32'h0);
    end

    // directed write transaction
    rxCount = 0;
    regWrite(2'd0, 8'hA0);
    regWrite(2'd3, 8'hA0);
    regWrite(2'd1, 8'hF0);
    waitPend();
    checkEq("R6 irq on pending", {31'd0, irq}, 32'd1);
    holdOk = 1'b1;
    sdaRef = sdaDriveLow;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (!sclDriveLow || sdaDriveLow != sdaRef) holdOk = 1'b0;
    end
    checkEq("R6 bus frozen while pending", {31'd0, holdOk}, 32'd1);
    regWrite(2'd0, 8'hB0);
    repeat (100) @(negedge clk);
    regRead(2'd0, v);
    checkEq("R2 writing pending=1 does not release", {31'd0, v[4]}, 32'd1);
    checkEq("R2 SCL still held", {31'd0, sclDriveLow}, 32'd1);
    regWrite(2'd3, 8'h3C);
    regWrite(2'd0, 8'hA0);
    regRead(2'd0, v);
    checkEq("R7 pending cleared on release", {31'd0, v[4]}, 32'd0);
    repeat (40) @(negedge clk);
    regWrite(2'd3, 8'h55);
    waitPend();
    regRead(2'd3, v);
    checkEq("R11 mid-byte write ignored", {24'd0, v}, 32'h3C);
    checkEq("R5 slave got data byte", {24'd0, rxMem[0]}, 32'h3C);
    regRead(2'd1, v);
    checkEq("R5 data ACK", {31'd0, v[0]}, 32'd0);
    regWrite(2'd3, 8'hFF);
    regWrite(2'd0, 8'hA0);
    waitPend();
    regRead(2'd1, v);
    checkEq("R5 data NACK", {31'd0, v[0]}, 32'd1);

    // R9 repeated START into a read of one byte
    s0 = startCnt; p0 = stopCnt;
    regWrite(2'd3, 8'hA1);
    regWrite(2'd1, 8'hB0);
    waitPend();
    checkEq("R9 repeated START seen", startCnt - s0, 1);
    checkEq("R9 no STOP before it", stopCnt - p0, 0);
    regRead(2'd1, v);
    checkEq("R9 status after restart", {24'd0, v}, 32'hB0);
    regWrite(2'd0, 8'h20);
    waitPend();
    regRead(2'd3, v);
    checkEq("R8 received byte", {24'd0, v}, {24'd0, pat(0)});
    checkEq("R8 master NACK with ack disabled", {31'd0, masterAck[0]}, 32'd1);
    regWrite(2'd1, 8'h90);
    waitIdle();
    checkEq("R10 STOP after read", stopCnt - p0, 1);

    // R8 read two bytes: ACK then NACK
    regWrite(2'd0, 8'hA0);
    regWrite(2'd3, 8'hA1);
    regWrite(2'd1, 8'hB0);
    waitPend();
    regWrite(2'd0, 8'hA0);
    waitPend();
    regRead(2'd3, v);
    checkEq("R8 first byte", {24'd0, v}, {24'd0, pat(0)});
    checkEq("R8 master ACK", {31'd0, masterAck[0]}, 32'd0);
    regWrite(2'd0, 8'h20);
    waitPend();
    regRead(2'd3, v);
    checkEq("R8 last byte", {24'd0, v}, {24'd0, pat(1)});
    checkEq("R8 master NACK last", {31'd0, masterAck[1]}, 32'd1);
    regWrite(2'd1, 8'h90);
    waitIdle();
    regRead(2'd1, v);
    checkEq("R10 busy cleared", {31'd0, v[5]}, 32'd0);
    checkEq("R10 lines released at end", {30'd0, sclDriveLow, sdaDriveLow}, 32'h0);

    finishRun();
  end

endmodule